// File: doc/BRIEF.md
# Timer-Paced Serial ADC Reader

This block reads a 16-bit serial converter at a fixed sample rate. A free-running interval timer produces one tick every `sample_period` system clocks. Each tick starts a frame. The block pulls an active-low chip select, drives a serial clock derived from the system clock, and shifts in the converter's data line on rising serial-clock edges. The serial clock idles high. Each half-period lasts `sclk_half` system clocks. When the frame ends, the 16-bit result is presented with a one-clock valid strobe.

A normal frame is 24 serial clocks long, which is three byte-sized groups. It holds 4 leading zeros, then 16 data bits MSB first, then 4 trailing zeros. The first leading zero is placed on the line by the chip-select fall and is never sampled. Rising edge k, counted from 1 after chip select falls, carries frame bit k+1. Rising edges 4 to 19 therefore carry the data bits, and edge 23 carries the last trailing zero.

Software can pulse a power-down request. The request is held until the next tick, and that tick then issues a short 8-clock burst, which leaves the converter powered down. The next full frame wakes the converter, and its result is marked as not trustworthy. A tick that arrives while a frame or its inter-frame gap is still running sets a sticky overrun flag. It does not disturb the frame in progress.

Top module: `adc_sampler`

## Requirements
- R1: While reset is asserted, `cs_n` and `sclk` are high, and `result_valid` and `overrun` are low.
- R2: With no overrun, `cs_n` falls exactly every `sample_period` system clocks.
- R3: In a frame of N serial clocks, `cs_n` stays low for (2N+1)·H system clocks, where H is `sclk_half`. `sclk` stays high for the first H clocks after `cs_n` falls, each low phase lasts H clocks, and `sclk` rises exactly N times. For a normal frame, N is 24.
- R4: `sclk` is high whenever `cs_n` is high, and `cs_n` stays high for at least 2·H clocks between frames.
- R5: `result_data` equals the bits seen on `sdata` at rising edges 4 through 19, taken MSB first. Rising edge 1 is the first rising edge after `cs_n` falls, and it sees the bit placed on the line by the first falling edge of `sclk`.
- R6: The bit on the line at the `cs_n` fall and the bits at rising edges 1–3 and 20–23 have no effect on `result_data`.
- R7: After a normal frame, `result_valid` is high for exactly one clock. That clock is the first one in which `cs_n` is high again, and `result_data` then holds the new result.
- R8: A one-clock `pd_req` pulse is held until the next tick. That tick issues a frame of only 8 serial clocks, with `cs_n` low for 17·H clocks and no `result_valid`.
- R9: The first normal frame after a power-down burst reports `result_wake`=1 with its `result_valid`. Later frames report `result_wake`=0.
- R10: A tick during a frame or gap sets `overrun`, which stays set until reset. The running frame keeps its normal length, and `overrun` stays 0 while ticks never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_period | input | TW (16) | System clocks between sample ticks |
| sclk_half | input | DW (8) | System clocks per serial-clock half-period |
| pd_req | input | 1 | Pulse to request a power-down burst at the next tick |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| result_valid | output | 1 | One-clock strobe for a new result |
| result_data | output | RES_W (16) | Last extracted conversion result |
| result_wake | output | 1 | Result came from the wake-up frame |
| overrun | output | 1 | Sticky flag: a tick came while busy |

## Verification
An off-by-one in the half-period index moves the capture window by one edge. On the next `result_valid`, that shows as a data word shifted by one bit, or as junk leaking in from the zero positions. The bench fills those positions with nonzero values so the error cannot hide. A miscounted frame length or divider phase shows within one frame as a wrong chip-select low time or rising-edge count. A lost power-down request or a wrong sleep state shows on the following two frames as a wrong burst length or a wrong wake flag.

// File: rtl/adc_sampler_pkg.sv
package adc_sampler_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_pace_timer.sv
module adc_pace_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  output logic          tick
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, period};
  assign tick = wrap;

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_sampler_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LONG_LEN = 24,
  parameter int PD_LEN   = 8,
  parameter int IDXW     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   half,
  input  logic            tick,
  input  logic            pd_req,
  output logic            cs_n,
  output logic            sclk,
  output logic            busy,
  output logic            rise,
  output logic [IDXW-1:0] rise_idx,
  output logic            done,
  output logic            done_pd,
  output logic            wake
);
  localparam int PW  = DW + 1;
  localparam int HPW = $clog2(2*LONG_LEN + 1);

  seq_state_t     st_q, st_d;
  logic [PW-1:0]  ph_q, ph_d;
  logic [HPW-1:0] hp_q, hp_d, last_hp;
  logic           cs_q, cs_d, sclk_q, sclk_d;
  logic           pdf_q, pdf_d, pend_q, pend_d;
  logic           asleep_q, asleep_d, wake_q, wake_d;
  logic           half_end, gap_end, start;

  assign half_end = (ph_q + PW'(1)) >= {1'b0, half};
  assign gap_end  = (ph_q + PW'(1)) >= {half, 1'b0};
  assign last_hp  = pdf_q ? HPW'(2*PD_LEN) : HPW'(2*LONG_LEN);
  assign start    = tick && (st_q == ST_IDLE);
  assign busy     = (st_q != ST_IDLE);
  assign rise     = (st_q == ST_FRAME) && half_end && hp_q[0];
  assign rise_idx = IDXW'((hp_q + HPW'(1)) >> 1);
  assign done     = (st_q == ST_FRAME) && half_end && (hp_q == last_hp);
  assign done_pd  = pdf_q;
  assign wake     = wake_q;
  assign cs_n     = cs_q;
  assign sclk     = sclk_q;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    hp_d     = hp_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    pdf_d    = pdf_q;
    asleep_d = asleep_q;
    wake_d   = wake_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_FRAME;
          cs_d     = 1'b0;
          sclk_d   = 1'b1;
          ph_d     = '0;
          hp_d     = '0;
          pdf_d    = pend_q;
          wake_d   = !pend_q && asleep_q;
          asleep_d = pend_q;
        end
      end
      ST_FRAME: begin
        if (half_end) begin
          ph_d = '0;
          if (hp_q == last_hp) begin
            st_d   = ST_GAP;
            cs_d   = 1'b1;
            sclk_d = 1'b1;
          end else begin
            hp_d   = hp_q + HPW'(1);
            sclk_d = hp_q[0];
          end
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end
      ST_GAP: begin
        if (gap_end) begin
          st_d = ST_IDLE;
          ph_d = '0;
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (start && pend_q) pend_d = pd_req;
    else                 pend_d = pend_q | pd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= '0;
      hp_q     <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      pdf_q    <= 1'b0;
      pend_q   <= 1'b0;
      asleep_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      hp_q     <= hp_d;
      cs_q     <= cs_d;
      sclk_q   <= sclk_d;
      pdf_q    <= pdf_d;
      pend_q   <= pend_d;
      asleep_q <= asleep_d;
      wake_q   <= wake_d;
    end
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int RES_W = 16,
  parameter int LEAD  = 4,
  parameter int IDXW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  input  logic             rise,
  input  logic [IDXW-1:0]  rise_idx,
  input  logic             done,
  input  logic             done_pd,
  input  logic             wake,
  output logic             result_valid,
  output logic [RES_W-1:0] result_data,
  output logic             result_wake
);
  localparam int WIN_END = LEAD + RES_W;

  logic [RES_W-1:0] sh_q, sh_d, data_q, data_d;
  logic             vld_q, vld_d, wk_q, wk_d;
  logic             in_win, shift_en, publish;

  assign in_win   = (rise_idx >= IDXW'(LEAD)) && (rise_idx < IDXW'(WIN_END));
  assign shift_en = rise && in_win;
  assign publish  = done && !done_pd;

  always_comb begin
    sh_d   = shift_en ? {sh_q[RES_W-2:0], sdata} : sh_q;
    data_d = publish ? sh_q : data_q;
    wk_d   = publish ? wake : wk_q;
    vld_d  = publish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      wk_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      data_q <= data_d;
      vld_q  <= vld_d;
      wk_q   <= wk_d;
    end
  end

  assign result_valid = vld_q;
  assign result_data  = data_q;
  assign result_wake  = wk_q;
endmodule

// File: rtl/adc_sampler.sv
module adc_sampler #(
  parameter int TW     = 16,
  parameter int DW     = 8,
  parameter int RES_W  = 16,
  parameter int LEAD   = 4,
  parameter int TRAIL  = 4,
  parameter int PD_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    sample_period,
  input  logic [DW-1:0]    sclk_half,
  input  logic             pd_req,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             result_valid,
  output logic [RES_W-1:0] result_data,
  output logic             result_wake,
  output logic             overrun
);
  localparam int LONG_LEN = LEAD + RES_W + TRAIL;
  localparam int IDXW     = $clog2(LONG_LEN + 1);

  logic            tick, busy, rise, done, done_pd, wake;
  logic [IDXW-1:0] rise_idx;
  logic            ovr_q, ovr_d;

  adc_pace_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(sample_period), .tick(tick)
  );

  adc_frame_seq #(
    .DW(DW), .LONG_LEN(LONG_LEN), .PD_LEN(PD_LEN), .IDXW(IDXW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .half(sclk_half), .tick(tick), .pd_req(pd_req),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .rise(rise), .rise_idx(rise_idx),
    .done(done), .done_pd(done_pd), .wake(wake)
  );

  adc_capture #(.RES_W(RES_W), .LEAD(LEAD), .IDXW(IDXW)) u_cap (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .rise(rise), .rise_idx(rise_idx),
    .done(done), .done_pd(done_pd), .wake(wake),
    .result_valid(result_valid), .result_data(result_data),
    .result_wake(result_wake)
  );

  assign ovr_d = ovr_q | (tick & busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun = ovr_q;
endmodule

// File: rtl/adc_sampler_chk.sv
module adc_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic result_valid,
  input logic overrun
);
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_sclk_fall_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !cs_n);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_valid_at_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $rose(cs_n));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind adc_sampler adc_sampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .result_valid(result_valid), .overrun(overrun)
);

// File: tb/adc_sampler_bench.sv
module adc_sampler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NLONG = 24;
  localparam int NPD   = 8;

  logic        clk, rst_n, pd_req, sdata;
  logic [15:0] sample_period;
  logic [7:0]  sclk_half;
  logic        cs_n, sclk, result_valid, result_wake, overrun;
  logic [15:0] result_data;

  int checks, fails;
  int cyc, t_fall, t_rise, t_sf, prev_fall, prev_rise, rises, bitpos, valid_cnt, low_run;
  bit half_bad;
  logic [23:0] frame_bits;

  adc_sampler u_adc_sampler (
    .clk(clk), .rst_n(rst_n), .sample_period(sample_period), .sclk_half(sclk_half),
    .pd_req(pd_req), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .result_valid(result_valid), .result_data(result_data),
    .result_wake(result_wake), .overrun(overrun)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  // converter model: chip-select fall places frame bit 1, each sclk fall the next
  initial begin
    sdata = 1'b0;
    forever begin
      @(negedge cs_n);
      bitpos = 0;
      rises  = 0;
      sdata  = frame_bits[23];
    end
  end

  initial begin
    forever begin
      @(negedge sclk);
      if (!cs_n) begin
        if (bitpos == 0) t_sf = cyc;
        bitpos++;
        sdata = (bitpos < 24) ? frame_bits[23-bitpos] : 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge sclk);
      if (!cs_n) rises++;
    end
  end

  initial begin
    valid_cnt = 0;
    low_run   = 0;
    half_bad  = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (result_valid) valid_cnt++;
        if (!sclk) low_run++;
        else begin
          if (low_run != 0 && low_run != int'(sclk_half)) half_bad = 1;
          low_run = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] d, input logic [7:0] junk,
                           input bit exp_wake, input bit is_pd, input bit chk_gap_period);
    int n, h, v0;
    n = is_pd ? NPD : NLONG;
    h = int'(sclk_half);
    frame_bits = {junk[7:4], d, junk[3:0]};
    half_bad = 0;
    @(negedge cs_n);
    t_fall = cyc;
    v0 = valid_cnt;
    if (chk_gap_period) begin
      chk(t_fall - prev_fall == int'(sample_period), "R2 tick spacing",
          t_fall - prev_fall, int'(sample_period));
      chk(t_fall - prev_rise >= 2*h, "R4 gap length", t_fall - prev_rise, 2*h);
    end
    prev_fall = t_fall;
    @(posedge cs_n);
    t_rise = cyc;
    prev_rise = t_rise;
    chk(t_rise - t_fall == (2*n+1)*h, is_pd ? "R8 burst cs low" : "R3 cs low",
        t_rise - t_fall, (2*n+1)*h);
    chk(rises == n, is_pd ? "R8 burst rises" : "R3 rises", rises, n);
    chk(t_sf - t_fall == h, "R3 setup high", t_sf - t_fall, h);
    chk(!half_bad, "R3 low phase", int'(half_bad), 0);
    @(negedge clk);
    if (is_pd) begin
      chk(!result_valid && valid_cnt == v0, "R8 no result", valid_cnt - v0, 0);
    end else begin
      chk(result_valid == 1'b1, "R7 valid", int'(result_valid), 1);
      chk(result_data == d, "R5 R6 data", int'(result_data), int'(d));
      chk(result_wake == exp_wake, "R9 wake", int'(result_wake), int'(exp_wake));
    end
    @(negedge clk);
    chk(result_valid == 1'b0, "R7 one clock", int'(result_valid), 0);
    if (!is_pd) chk(result_data == d, "R7 held", int'(result_data), int'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    prev_fall = 0;
    prev_rise = 0;
    rst_n = 1'b0;
    pd_req = 1'b0;
    frame_bits = '0;
    sclk_half = 8'd1;
    sample_period = 16'd61;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk, "R1 cs/sclk reset", int'({cs_n, sclk}), 3);
    chk(!result_valid && !overrun, "R1 flags reset", int'({result_valid, overrun}), 0);
    rst_n = 1'b1;
    for (int h = 1; h <= 3; h++) begin
      sclk_half = 8'(h);
      sample_period = 16'((2*NLONG + 3)*h + 10);
      for (int i = 0; i < 20; i++) begin
        logic [15:0] d;
        logic [7:0]  j;
        d = (i < 16) ? (16'h1 << i) : 16'(i*16'h9E37 + 16'h5A5A + h);
        j = 8'(i*8'h4D) ^ 8'hA5 ^ 8'(h);
        if (i == 3) j = 8'hFF;
        run_frame(d, j, 1'b0, 1'b0, i > 0);
        if (h == 2 && i == 10) begin
          pd_req = 1'b1;
          @(negedge clk);
          pd_req = 1'b0;
          run_frame(16'h0, 8'h00, 1'b0, 1'b1, 1'b1);
          run_frame(16'hC3A5, 8'hF0, 1'b1, 1'b0, 1'b1);
          run_frame(16'h3C5A, 8'h0F, 1'b0, 1'b0, 1'b1);
        end
      end
    end
    chk(overrun == 1'b0, "R10 no overrun", int'(overrun), 0);
    sclk_half = 8'd2;
    sample_period = 16'd40;
    run_frame(16'hBEEF, 8'h99, 1'b0, 1'b0, 1'b0);
    chk(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
    run_frame(16'h1357, 8'h66, 1'b0, 1'b0, 1'b0);
    chk(overrun == 1'b1, "R10 overrun sticky", int'(overrun), 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule